// File: doc/BRIEF.md
# Transient Buffer Dump Controller

This block replays a stretch of previously recorded pages from a paged capture memory. Software chooses one input channel, a first page and a number of pages, then raises a dump-enable level. The controller walks the pages in ascending order, wrapping at the end of the page space. It fetches every word of each page through a simple request/response read port and sends each page downstream as one framed packet, marked with start-of-packet and end-of-packet.

Between packets it waits a programmable number of idle cycles. Per-input counters track progress: packets read, packets dropped because a memory word came back with an error flag, packets still remaining, and packets dumped cleanly. A separate clear control zeroes the counters. Dropping dump-enable stops the dump straight away. A status output stays high until the controller is actually quiet again.

Top module: `tbuf_dump_ctrl`

## Requirements
- R1: While idle with `dump_enable` high, a dump of `cfg_num_packets` pages starts for input `cfg_input`, beginning at `cfg_start_page`. Pages are read in ascending order, with the page index wrapping modulo 2^PAGE_AW. Within a page, words are read in ascending order. `mem_addr` is {input, page, word} from MSB to LSB, and exactly one request is made per word.
- R2: Each page leaves as one packet of WORDS_PER_PAGE beats on `out_valid`. `out_sop` is set on the first beat only, `out_eop` on the last beat only, and `out_data` is the word returned by memory.
- R3: The read counter of the dumped input rises by one for each completed page. At the end of an undisturbed dump it has grown by the requested count.
- R4: At dump start, the remaining counter of the selected input loads the requested count. It falls by one per completed page and reads 0 when the dump has finished.
- R5: A page that had `mem_rerr` high on any of its words counts as dropped; otherwise it counts as dumped. `out_err` is set on that packet's end-of-packet beat and is 0 on every other beat of a normal packet. For every input, dumped plus dropped equals read.
- R6: A one-cycle pulse on `clear_counts` zeroes every counter of every input on the next clock edge, independent of `dump_enable`.
- R7: Between an end-of-packet beat and the next start-of-packet beat of the same dump there are at least `cfg_gap` cycles with `out_valid` low.
- R8: Once `dump_enable` is low, no memory request is issued. If a packet has been partly emitted, one terminating beat follows with `out_eop`=1, `out_err`=1, `out_sop`=0 and `out_data`=0. The partial page is not counted in any counter.
- R9: An abort while waiting between packets emits no further beat.
- R10: `dump_active` is high from dump start until the controller has stopped, and low out of reset. After a dump ends, no beats or requests occur while `dump_enable` stays high; a new dump needs `dump_enable` to go low and then high again.
- R11: A requested count of zero finishes at once with no memory request and no beat, and leaves the remaining counter at 0.
- R12: Counters are kept per input; a dump of one input leaves the other inputs' counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dump_enable | input | 1 | Level: start or continue dump; low aborts |
| cfg_input | input | IN_W | Input channel to dump |
| cfg_start_page | input | PAGE_AW | First page of the interval |
| cfg_num_packets | input | CNT_W | Number of pages (packets) to dump |
| cfg_gap | input | GAP_W | Minimum idle cycles between packets |
| clear_counts | input | 1 | Pulse: zero all counters |
| dump_active | output | 1 | High while a dump has not yet stopped |
| mem_req | output | 1 | One-cycle word read request |
| mem_addr | output | ADDR_W | {input, page, word} read address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | DATA_W | Read response data |
| mem_rerr | input | 1 | Read response error flag |
| out_valid | output | 1 | Output beat valid |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | Last beat of a packet |
| out_err | output | 1 | Packet bad or aborted (on end beat) |
| out_data | output | DATA_W | Output beat data |
| cnt_read | output | NUM_IN*CNT_W | Per-input packets read |
| cnt_dropped | output | NUM_IN*CNT_W | Per-input packets with read errors |
| cnt_remaining | output | NUM_IN*CNT_W | Per-input packets still to read |
| cnt_dumped | output | NUM_IN*CNT_W | Per-input packets read cleanly |

## Verification
The bench builds the block with two inputs, sixteen pages of four 16-bit words, 8-bit counters and a 4-bit gap setting. This is small enough to sweep both inputs, a start page that wraps past the last page, counts of zero, one and four, and gaps of zero and five, while checking every beat against data computed from the address. With pages this short, an abort after the second start-of-packet and an abort inside the gap can each be timed to a single cycle. A word error injected on one page exercises the dropped and dumped split.

// File: rtl/tbuf_dump_pkg.sv
// Package: shared state encoding and width helper for the dump controller.
// Assumes: nothing beyond IEEE 1800-2017.
package tbuf_dump_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ISSUE = 3'd1,
        ST_WAIT  = 3'd2,
        ST_GAP   = 3'd3,
        ST_DRAIN = 3'd4,
        ST_DONE  = 3'd5
    } dump_state_e;

    // Index width for a count of items, never below one bit.
    function automatic int unsigned idx_width(int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/tbuf_gap_timer.sv
// Module: tbuf_gap_timer
// Counts down the inter-packet idle time. Loading sets the count to the
// programmed gap; the timer reports expiry once the count reaches zero.
// Assumes: load is a one-cycle pulse at each end-of-packet.
module tbuf_gap_timer #(
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] gap_in,
    output logic             expired
);

    logic [GAP_W-1:0] remain_q;

    // Load on packet end, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= gap_in;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - GAP_W'(1);
        end
    end

    assign expired = (remain_q == '0);

endmodule

// File: rtl/tbuf_pkt_counters.sv
// Module: tbuf_pkt_counters
// One bank of four progress counters per input: read, dropped, remaining,
// dumped. Clear zeroes every bank and wins over any update in that cycle.
// Assumes: start and pkt_done are never high in the same cycle.
module tbuf_pkt_counters #(
    parameter int NUM_IN = 2,
    parameter int CNT_W  = 8,
    parameter int IN_W   = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    start,
    input  logic [IN_W-1:0]         start_in,
    input  logic [CNT_W-1:0]        start_num,
    input  logic                    pkt_done,
    input  logic [IN_W-1:0]         pkt_in,
    input  logic                    pkt_bad,
    output logic [NUM_IN*CNT_W-1:0] read_o,
    output logic [NUM_IN*CNT_W-1:0] dropped_o,
    output logic [NUM_IN*CNT_W-1:0] remaining_o,
    output logic [NUM_IN*CNT_W-1:0] dumped_o
);

    for (genvar i = 0; i < NUM_IN; i++) begin : g_bank
        logic [CNT_W-1:0] read_q, drop_q, rem_q, dump_q;
        logic             sel_start, sel_pkt;

        assign sel_start = start    && (start_in == IN_W'(i));
        assign sel_pkt   = pkt_done && (pkt_in   == IN_W'(i));

        // Per-input counter update: clear, load at start, step per page.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                read_q <= '0;
                drop_q <= '0;
                rem_q  <= '0;
                dump_q <= '0;
            end else if (sel_start) begin
                rem_q <= start_num;
            end else if (sel_pkt) begin
                read_q <= read_q + CNT_W'(1);
                rem_q  <= rem_q - CNT_W'(1);
                if (pkt_bad) begin
                    drop_q <= drop_q + CNT_W'(1);
                end else begin
                    dump_q <= dump_q + CNT_W'(1);
                end
            end
        end

        assign read_o[i*CNT_W +: CNT_W]      = read_q;
        assign dropped_o[i*CNT_W +: CNT_W]   = drop_q;
        assign remaining_o[i*CNT_W +: CNT_W] = rem_q;
        assign dumped_o[i*CNT_W +: CNT_W]    = dump_q;
    end

endmodule

// File: rtl/tbuf_dump_seq.sv
// Module: tbuf_dump_seq
// Sequencer for one dump: walks pages and words, issues one memory request
// at a time, frames the returned words into packets, handles abort and
// reports per-page events to the counters.
// Assumes: memory returns exactly one response per request, in order.
module tbuf_dump_seq import tbuf_dump_pkg::*; #(
    parameter int IN_W           = 1,
    parameter int PAGE_AW        = 4,
    parameter int WORDS_PER_PAGE = 4,
    parameter int DATA_W         = 16,
    parameter int CNT_W          = 8,
    localparam int WORD_W        = idx_width(WORDS_PER_PAGE),
    localparam int ADDR_W        = IN_W + PAGE_AW + WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dump_enable,
    input  logic [IN_W-1:0]    cfg_input,
    input  logic [PAGE_AW-1:0] cfg_start_page,
    input  logic [CNT_W-1:0]   cfg_num_packets,
    input  logic               gap_expired,
    output logic               gap_load,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_rvalid,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               mem_rerr,
    output logic               out_valid,
    output logic               out_sop,
    output logic               out_eop,
    output logic               out_err,
    output logic [DATA_W-1:0]  out_data,
    output logic               dump_active,
    output logic               ev_start,
    output logic               ev_pkt_done,
    output logic               ev_pkt_bad,
    output logic [IN_W-1:0]    ev_pkt_in
);

    localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(WORDS_PER_PAGE - 1);

    dump_state_e        state_q;
    logic [IN_W-1:0]    in_q;
    logic [PAGE_AW-1:0] page_q;
    logic [WORD_W-1:0]  word_q;
    logic [CNT_W-1:0]   left_q;
    logic               open_q;
    logic               perr_q;
    logic               last_word;

    assign last_word = (word_q == LAST_WORD);

    // Main sequencer and registered output stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            in_q      <= '0;
            page_q    <= '0;
            word_q    <= '0;
            left_q    <= '0;
            open_q    <= 1'b0;
            perr_q    <= 1'b0;
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_err   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_err   <= 1'b0;
            out_data  <= '0;
            unique case (state_q)
                ST_IDLE: begin
                    if (dump_enable) begin
                        in_q    <= cfg_input;
                        page_q  <= cfg_start_page;
                        word_q  <= '0;
                        left_q  <= cfg_num_packets;
                        open_q  <= 1'b0;
                        perr_q  <= 1'b0;
                        state_q <= (cfg_num_packets == '0) ? ST_DONE : ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (!dump_enable) begin
                        if (open_q) begin
                            out_valid <= 1'b1;
                            out_eop   <= 1'b1;
                            out_err   <= 1'b1;
                        end
                        open_q  <= 1'b0;
                        state_q <= ST_DONE;
                    end else begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (!dump_enable) begin
                        if (open_q) begin
                            out_valid <= 1'b1;
                            out_eop   <= 1'b1;
                            out_err   <= 1'b1;
                        end
                        open_q  <= 1'b0;
                        state_q <= mem_rvalid ? ST_DONE : ST_DRAIN;
                    end else if (mem_rvalid) begin
                        out_valid <= 1'b1;
                        out_data  <= mem_rdata;
                        out_sop   <= (word_q == '0);
                        out_eop   <= last_word;
                        out_err   <= last_word && (perr_q || mem_rerr);
                        if (last_word) begin
                            open_q  <= 1'b0;
                            perr_q  <= 1'b0;
                            word_q  <= '0;
                            page_q  <= page_q + PAGE_AW'(1);
                            left_q  <= left_q - CNT_W'(1);
                            state_q <= (left_q == CNT_W'(1)) ? ST_DONE : ST_GAP;
                        end else begin
                            open_q  <= 1'b1;
                            perr_q  <= perr_q || mem_rerr;
                            word_q  <= word_q + WORD_W'(1);
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_GAP: begin
                    if (!dump_enable) begin
                        state_q <= ST_DONE;
                    end else if (gap_expired) begin
                        state_q <= ST_ISSUE;
                    end
                end
                ST_DRAIN: begin
                    if (mem_rvalid) begin
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    if (!dump_enable) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Request, address and status decode.
    always_comb begin
        mem_req     = (state_q == ST_ISSUE) && dump_enable;
        mem_addr    = {in_q, page_q, word_q};
        dump_active = (state_q == ST_ISSUE) || (state_q == ST_WAIT) ||
                      (state_q == ST_GAP)   || (state_q == ST_DRAIN);
        ev_start    = (state_q == ST_IDLE) && dump_enable;
        ev_pkt_done = (state_q == ST_WAIT) && dump_enable && mem_rvalid && last_word;
        ev_pkt_bad  = perr_q || mem_rerr;
        ev_pkt_in   = in_q;
        gap_load    = ev_pkt_done;
    end

endmodule

// File: rtl/tbuf_dump_ctrl.sv
// Module: tbuf_dump_ctrl (top)
// Dump controller for a paged transient buffer: sequencer, inter-packet
// gap timer and per-input progress counters.
// Assumes: configuration inputs are held stable while a dump is active.
module tbuf_dump_ctrl import tbuf_dump_pkg::*; #(
    parameter int NUM_IN         = 2,
    parameter int PAGE_AW        = 4,
    parameter int WORDS_PER_PAGE = 4,
    parameter int DATA_W         = 16,
    parameter int CNT_W          = 8,
    parameter int GAP_W          = 4,
    localparam int IN_W          = idx_width(NUM_IN),
    localparam int WORD_W        = idx_width(WORDS_PER_PAGE),
    localparam int ADDR_W        = IN_W + PAGE_AW + WORD_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dump_enable,
    input  logic [IN_W-1:0]         cfg_input,
    input  logic [PAGE_AW-1:0]      cfg_start_page,
    input  logic [CNT_W-1:0]        cfg_num_packets,
    input  logic [GAP_W-1:0]        cfg_gap,
    input  logic                    clear_counts,
    output logic                    dump_active,
    output logic                    mem_req,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic                    mem_rvalid,
    input  logic [DATA_W-1:0]       mem_rdata,
    input  logic                    mem_rerr,
    output logic                    out_valid,
    output logic                    out_sop,
    output logic                    out_eop,
    output logic                    out_err,
    output logic [DATA_W-1:0]       out_data,
    output logic [NUM_IN*CNT_W-1:0] cnt_read,
    output logic [NUM_IN*CNT_W-1:0] cnt_dropped,
    output logic [NUM_IN*CNT_W-1:0] cnt_remaining,
    output logic [NUM_IN*CNT_W-1:0] cnt_dumped
);

    logic            gap_load, gap_expired;
    logic            ev_start, ev_pkt_done, ev_pkt_bad;
    logic [IN_W-1:0] ev_pkt_in;

    tbuf_dump_seq #(
        .IN_W          (IN_W),
        .PAGE_AW       (PAGE_AW),
        .WORDS_PER_PAGE(WORDS_PER_PAGE),
        .DATA_W        (DATA_W),
        .CNT_W         (CNT_W)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .dump_enable    (dump_enable),
        .cfg_input      (cfg_input),
        .cfg_start_page (cfg_start_page),
        .cfg_num_packets(cfg_num_packets),
        .gap_expired    (gap_expired),
        .gap_load       (gap_load),
        .mem_req        (mem_req),
        .mem_addr       (mem_addr),
        .mem_rvalid     (mem_rvalid),
        .mem_rdata      (mem_rdata),
        .mem_rerr       (mem_rerr),
        .out_valid      (out_valid),
        .out_sop        (out_sop),
        .out_eop        (out_eop),
        .out_err        (out_err),
        .out_data       (out_data),
        .dump_active    (dump_active),
        .ev_start       (ev_start),
        .ev_pkt_done    (ev_pkt_done),
        .ev_pkt_bad     (ev_pkt_bad),
        .ev_pkt_in      (ev_pkt_in)
    );

    tbuf_gap_timer #(
        .GAP_W(GAP_W)
    ) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (gap_load),
        .gap_in (cfg_gap),
        .expired(gap_expired)
    );

    tbuf_pkt_counters #(
        .NUM_IN(NUM_IN),
        .CNT_W (CNT_W),
        .IN_W  (IN_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clear_counts),
        .start      (ev_start),
        .start_in   (cfg_input),
        .start_num  (cfg_num_packets),
        .pkt_done   (ev_pkt_done),
        .pkt_in     (ev_pkt_in),
        .pkt_bad    (ev_pkt_bad),
        .read_o     (cnt_read),
        .dropped_o  (cnt_dropped),
        .remaining_o(cnt_remaining),
        .dumped_o   (cnt_dumped)
    );

endmodule

// File: rtl/tbuf_dump_ctrl_chk.sv
// Module: tbuf_dump_ctrl_chk
// Temporal checks on the dump controller's ports, bound to every instance.
// Assumes: cfg_gap is held stable while a dump is active.
module tbuf_dump_ctrl_chk #(
    parameter int NUM_IN = 2,
    parameter int CNT_W  = 8,
    parameter int GAP_W  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    dump_enable,
    input logic                    dump_active,
    input logic                    mem_req,
    input logic [GAP_W-1:0]        cfg_gap,
    input logic                    clear_counts,
    input logic                    out_valid,
    input logic                    out_sop,
    input logic                    out_eop,
    input logic [NUM_IN*CNT_W-1:0] cnt_read,
    input logic [NUM_IN*CNT_W-1:0] cnt_dropped,
    input logic [NUM_IN*CNT_W-1:0] cnt_remaining,
    input logic [NUM_IN*CNT_W-1:0] cnt_dumped
);

    logic [15:0] idle_q;
    logic        seen_eop_q;

    // Idle cycles since the last end-of-packet within the current dump.
    always_ff @(posedge clk) begin
        if (!rst_n || !dump_active) begin
            idle_q     <= '0;
            seen_eop_q <= 1'b0;
        end else if (out_valid && out_eop) begin
            idle_q     <= '0;
            seen_eop_q <= 1'b1;
        end else if (!out_valid && idle_q != 16'hFFFF) begin
            idle_q <= idle_q + 16'd1;
        end
    end

    assert_req_in_dump_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> dump_active)
        else $error("memory request outside a dump");

    assert_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dump_enable |-> !mem_req)
        else $error("memory request while dump disabled");

    assert_min_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop && seen_eop_q) |-> (idle_q >= 16'(cfg_gap)))
        else $error("inter-packet gap too short");

    assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!dump_active && $past(!dump_active)) |-> !out_valid)
        else $error("beat emitted after dump stopped");

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_counts |=> (cnt_read == '0 && cnt_dropped == '0 &&
                          cnt_remaining == '0 && cnt_dumped == '0))
        else $error("counters not cleared");

    for (genvar i = 0; i < NUM_IN; i++) begin : g_tally
        assert_tally_R5: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_read[i*CNT_W +: CNT_W] ==
                CNT_W'(cnt_dropped[i*CNT_W +: CNT_W] + cnt_dumped[i*CNT_W +: CNT_W]))
            else $error("read differs from dropped plus dumped");
    end

endmodule

bind tbuf_dump_ctrl tbuf_dump_ctrl_chk #(
    .NUM_IN(NUM_IN),
    .CNT_W (CNT_W),
    .GAP_W (GAP_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dump_enable  (dump_enable),
    .dump_active  (dump_active),
    .mem_req      (mem_req),
    .cfg_gap      (cfg_gap),
    .clear_counts (clear_counts),
    .out_valid    (out_valid),
    .out_sop      (out_sop),
    .out_eop      (out_eop),
    .cnt_read     (cnt_read),
    .cnt_dropped  (cnt_dropped),
    .cnt_remaining(cnt_remaining),
    .cnt_dumped   (cnt_dumped)
);

// File: tb/tbuf_dump_ctrl_bench.sv
`timescale 1ns/1ps
// Bench: sweeps inputs, start pages, counts and gaps on a small build,
// then error injection, clear and both abort cases.
module tbuf_dump_ctrl_bench;

    localparam int NUM_IN = 2;
    localparam int PAGE_AW = 4;
    localparam int WORDS = 4;
    localparam int DATA_W = 16;
    localparam int CNT_W = 8;
    localparam int GAP_W = 4;
    localparam int NPAGES = 1 << PAGE_AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic                    dump_enable = 1'b0;
    logic [0:0]              cfg_input = '0;
    logic [PAGE_AW-1:0]      cfg_start_page = '0;
    logic [CNT_W-1:0]        cfg_num_packets = '0;
    logic [GAP_W-1:0]        cfg_gap = '0;
    logic                    clear_counts = 1'b0;
    logic                    dump_active, mem_req;
    logic [6:0]              mem_addr;
    logic                    mem_rvalid;
    logic [DATA_W-1:0]       mem_rdata;
    logic                    mem_rerr;
    logic                    out_valid, out_sop, out_eop, out_err;
    logic [DATA_W-1:0]       out_data;
    logic [NUM_IN*CNT_W-1:0] cnt_read, cnt_dropped, cnt_remaining, cnt_dumped;

    tbuf_dump_ctrl #(
        .NUM_IN(NUM_IN), .PAGE_AW(PAGE_AW), .WORDS_PER_PAGE(WORDS),
        .DATA_W(DATA_W), .CNT_W(CNT_W), .GAP_W(GAP_W)
    ) u_tbuf_dump_ctrl (
        .clk(clk), .rst_n(rst_n), .dump_enable(dump_enable),
        .cfg_input(cfg_input), .cfg_start_page(cfg_start_page),
        .cfg_num_packets(cfg_num_packets), .cfg_gap(cfg_gap),
        .clear_counts(clear_counts), .dump_active(dump_active),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_rerr(mem_rerr), .out_valid(out_valid),
        .out_sop(out_sop), .out_eop(out_eop), .out_err(out_err),
        .out_data(out_data), .cnt_read(cnt_read), .cnt_dropped(cnt_dropped),
        .cnt_remaining(cnt_remaining), .cnt_dumped(cnt_dumped)
    );

    // Memory model: one-cycle latency, data derived from the address.
    function automatic int mem_word(int a);
        return (a * 37 + 256) & 16'hFFFF;
    endfunction

    logic       m_valid = 1'b0;
    logic [6:0] m_addr = '0;
    bit         err_on = 0;
    int         err_in = 0, err_page = 0;

    always @(posedge clk) begin
        m_valid <= mem_req;
        m_addr  <= mem_addr;
    end
    assign mem_rvalid = m_valid;
    assign mem_rdata  = DATA_W'(mem_word(int'(m_addr)));
    assign mem_rerr   = m_valid && err_on && (int'(m_addr[6]) == err_in) &&
                        (int'(m_addr[5:2]) == err_page) && (m_addr[1:0] == 2'd1);

    // Result bookkeeping.
    int  n_tests = 0, n_fail = 0;
    bit  done = 0;

    task automatic check(string req, string what, longint act, longint exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Output monitor.
    int          nb = 0, nreq = 0, min_idle = 1000, idle = 0;
    bit          had_eop = 0;
    logic [15:0] bd [0:127];
    bit          bs [0:127];
    bit          be [0:127];
    bit          br [0:127];

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req) nreq++;
            if (out_valid) begin
                if (nb < 128) begin
                    bd[nb] = out_data; bs[nb] = out_sop;
                    be[nb] = out_eop;  br[nb] = out_err;
                end
                nb++;
                if (out_sop && had_eop && idle < min_idle) min_idle = idle;
                if (out_eop) begin had_eop = 1; idle = 0; end
            end else begin
                idle++;
            end
        end
    end

    // Counter model.
    int m_read [NUM_IN];
    int m_drop [NUM_IN];
    int m_rem  [NUM_IN];
    int m_dump [NUM_IN];

    function automatic int sl(logic [NUM_IN*CNT_W-1:0] v, int i);
        return int'(v[i*CNT_W +: CNT_W]);
    endfunction

    task automatic model_clear();
        for (int i = 0; i < NUM_IN; i++) begin
            m_read[i] = 0; m_drop[i] = 0; m_rem[i] = 0; m_dump[i] = 0;
        end
    endtask

    task automatic check_counters(int active_in);
        for (int i = 0; i < NUM_IN; i++) begin
            check(i == active_in ? "R3" : "R12", $sformatf("read[%0d]", i), sl(cnt_read, i), m_read[i]);
            check(i == active_in ? "R4" : "R12", $sformatf("remaining[%0d]", i), sl(cnt_remaining, i), m_rem[i]);
            check(i == active_in ? "R5" : "R12", $sformatf("dropped[%0d]", i), sl(cnt_dropped, i), m_drop[i]);
            check(i == active_in ? "R5" : "R12", $sformatf("dumped[%0d]", i), sl(cnt_dumped, i), m_dump[i]);
        end
    endtask

    task automatic pulse_clear();
        @(negedge clk); clear_counts = 1'b1;
        @(negedge clk); clear_counts = 1'b0;
        model_clear();
    endtask

    task automatic start_dump(int in, int sp, int n, int gap);
        @(negedge clk);
        cfg_input = 1'(in); cfg_start_page = PAGE_AW'(sp);
        cfg_num_packets = CNT_W'(n); cfg_gap = GAP_W'(gap);
        nb = 0; nreq = 0; min_idle = 1000; idle = 0; had_eop = 0;
        dump_enable = 1'b1;
    endtask

    task automatic wait_stopped();
        repeat (2) @(negedge clk);
        for (int k = 0; k < 5000 && dump_active; k++) @(negedge clk);
    endtask

    task automatic full_dump(int in, int sp, int n, int gap);
        int bad;
        start_dump(in, sp, n, gap);
        wait_stopped();
        repeat (3) @(negedge clk);
        check("R10", "no beats while enable held after end", nb, n * WORDS);
        dump_enable = 1'b0;
        repeat (2) @(negedge clk);
        check("R10", "dump_active low after end", dump_active, 0);
        bad = 0;
        for (int p = 0; p < n; p++) begin
            int pg = (sp + p) % NPAGES;
            bit pbad = err_on && in == err_in && pg == err_page;
            if (pbad) bad++;
            for (int w = 0; w < WORDS; w++) begin
                int ix = p * WORDS + w;
                int a = in * NPAGES * WORDS + pg * WORDS + w;
                check("R1", $sformatf("data p%0d w%0d", p, w), bd[ix], mem_word(a));
                check("R2", $sformatf("sop p%0d w%0d", p, w), bs[ix], w == 0);
                check("R2", $sformatf("eop p%0d w%0d", p, w), be[ix], w == WORDS - 1);
                check("R5", $sformatf("err p%0d w%0d", p, w), br[ix], pbad && w == WORDS - 1);
            end
        end
        check("R2", "beat count", nb, n * WORDS);
        check("R1", "request count", nreq, n * WORDS);
        if (n == 0) check("R11", "zero count gives no request", nreq, 0);
        if (n >= 2) check("R7", "minimum idle >= gap", min_idle >= gap, 1);
        m_read[in] += n; m_rem[in] = 0; m_drop[in] += bad; m_dump[in] += n - bad;
        check_counters(in);
    endtask

    // Watchdog.
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (4) @(negedge clk);
        check("R10", "reset dump_active", dump_active, 0);
        check("R10", "reset out_valid", out_valid, 0);
        check("R1", "reset mem_req", mem_req, 0);
        check_counters(0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Sweep: inputs, start pages (13 wraps), counts, gaps.
        for (int in = 0; in < NUM_IN; in++)
            for (int s = 0; s < 2; s++)
                for (int n = 0; n < 3; n++)
                    for (int g = 0; g < 2; g++)
                        full_dump(in, s == 0 ? 0 : 13, n == 0 ? 0 : (n == 1 ? 1 : 4), g * 5);

        // R6: clear zeroes every counter.
        pulse_clear();
        check_counters(0);

        // R5: word error on page 2 of input 1.
        err_on = 1; err_in = 1; err_page = 2;
        full_dump(1, 0, 4, 1);
        err_on = 0;

        // R8: abort right after the second packet starts.
        pulse_clear();
        start_dump(0, 3, 5, 2);
        begin
            int k = 0;
            for (int t = 0; t < 500 && k < 2; t++) begin
                @(negedge clk);
                if (out_valid && out_sop) k++;
            end
        end
        dump_enable = 1'b0;
        wait_stopped();
        repeat (2) @(negedge clk);
        check("R8", "beats with terminator", nb, WORDS + 2);
        check("R8", "terminator eop", be[WORDS + 1], 1);
        check("R8", "terminator err", br[WORDS + 1], 1);
        check("R8", "terminator sop", bs[WORDS + 1], 0);
        check("R8", "terminator data", bd[WORDS + 1], 0);
        check("R8", "requests stop", nreq, WORDS + 1);
        check("R10", "stopped after abort", dump_active, 0);
        m_read[0] = 1; m_rem[0] = 4; m_dump[0] = 1;
        check_counters(0);

        // R9: abort inside the gap.
        pulse_clear();
        start_dump(1, 7, 3, 6);
        for (int t = 0; t < 500; t++) begin
            @(negedge clk);
            if (out_valid && out_eop) break;
        end
        @(negedge clk);
        dump_enable = 1'b0;
        wait_stopped();
        repeat (2) @(negedge clk);
        check("R9", "no beat after gap abort", nb, WORDS);
        check("R9", "last beat clean", br[WORDS - 1], 0);
        check("R9", "requests", nreq, WORDS);
        m_read[1] = 1; m_rem[1] = 2; m_dump[1] = 1;
        check_counters(1);

        // R11 after non-empty history: zero count leaves remaining at 0.
        full_dump(1, 5, 0, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule